// File: doc/BRIEF.md
# Crossing Fragment Collector with Per-Trigger Accept Queues

This block joins result fragments that several trigger sources produce for each beam crossing. The fragments reach it in any order and are matched only by their crossing number. A crossing is evaluated once every source has reported for it. Each trigger compares the joined result bits against its own criteria mask. A per-trigger prescale then decides whether the crossing is accepted. An accepted crossing raises a one-cycle accept pulse, and its crossing number is appended to the queue that belongs to each trigger that fired.

Crossings waiting to be joined sit in a direct-mapped table, indexed by the low bits of the crossing number. A crossing that stays incomplete for too long is recovered. It is evaluated with the bits of the missing sources at zero and is marked as timed out. Downstream consumers ask for the next accepted crossing of a given trigger. They get either the oldest queued crossing number or a not-available answer, one cycle after the request, with no stall.

Top module: `trg_collect`

## Requirements
- R1: After reset no accept and no collision is reported, no response is pending, and every trigger queue is empty.
- R2: Fragments for one crossing are joined in any arrival order. Source s supplies bits [s*RW +: RW] of the joined result. A fragment that completes a crossing at clock edge E produces the accept outputs in the cycle that follows edge E+1.
- R3: No accept is issued for a crossing while any of its sources is still missing, until its timeout expires.
- R4: Trigger t passes when every bit of its mask (cfg_mask[t*CW +: CW]) is set in the joined result.
- R5: With prescale N = cfg_prescale[t*PSW +: PSW], trigger t accepts every Nth passing crossing: the Nth, 2Nth and so on. N = 0 disables the trigger.
- R6: An accept drives acc_pulse for one cycle, with acc_trig bit t set for each trigger that fired, acc_xing holding the crossing number, and acc_timeout holding the recovery flag.
- R7: Each accepted crossing is appended to the queue of every trigger that fired. A request (req_valid with req_trig = t) returns the oldest entry of queue t and removes it. resp_valid, resp_avail and resp_xing appear in the cycle after the request edge.
- R8: A request to an empty queue returns resp_valid = 1 and resp_avail = 0, and leaves the queue unchanged.
- R9: An accept that finds a queue full with QDEPTH entries is dropped for that queue. The entries already queued stay in order.
- R10: A crossing that is still incomplete TIMEOUT cycles after its first fragment is evaluated with the missing sources' bits at zero, and acc_timeout = 1. The accept appears TIMEOUT+2 edges after the edge that stored the first fragment.
- R11: A fragment whose table slot (low SLOT_W bits of the crossing number) holds a different pending crossing raises err_collision for one cycle. The older crossing is discarded and never accepted, and the new one starts in that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frag_valid | input | 1 | Fragment present this cycle |
| frag_src | input | SRCW | Source index of the fragment |
| frag_xing | input | XW | Crossing number of the fragment |
| frag_bits | input | RW | Result bits from that source |
| cfg_mask | input | NTRIG*CW | Criteria mask per trigger |
| cfg_prescale | input | NTRIG*PSW | Prescale per trigger, 0 disables |
| req_valid | input | 1 | Request for the next accepted crossing |
| req_trig | input | TW | Trigger whose queue is asked |
| acc_pulse | output | 1 | Accept strobe |
| acc_trig | output | NTRIG | Triggers that fired |
| acc_xing | output | XW | Accepted crossing number |
| acc_timeout | output | 1 | Accepted crossing was recovered by timeout |
| err_collision | output | 1 | Slot collision strobe |
| resp_valid | output | 1 | Response to a request |
| resp_avail | output | 1 | Response carries a crossing |
| resp_xing | output | XW | Crossing number returned |

## Verification
The hardest states to reach from the ports are a slot eviction and a timeout recovery that land on exact cycles, because both depend on the table holding a partial crossing. The bench leaves crossings deliberately incomplete. For the timeout it counts edges from the first stored fragment to the accept. For the collision it sends a second crossing number that aliases to the same slot, then watches for longer than the timeout to confirm that the evicted crossing never reappears. A sweep over all six source arrival orders and every 6-bit result pattern exercises the joining and the masks. Separate runs fill a queue past its depth and apply a divide-by-three and a zero prescale.

// File: rtl/trg_collect_pkg.sv
package trg_collect_pkg;
  typedef enum logic [1:0] {
    OP_IDLE    = 2'd0,
    OP_MERGE   = 2'd1,
    OP_INSTALL = 2'd2,
    OP_EVICT   = 2'd3
  } slot_op_e;
endpackage

// File: rtl/trg_frag_table.sv
module trg_frag_table
  import trg_collect_pkg::*;
#(
  parameter int NSRC    = 3,
  parameter int RW      = 2,
  parameter int XW      = 6,
  parameter int SLOT_W  = 2,
  parameter int TIMEOUT = 12,
  localparam int SRCW   = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int CW     = NSRC * RW,
  localparam int NSL    = 1 << SLOT_W,
  localparam int TOW    = $clog2(TIMEOUT + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frag_valid,
  input  logic [SRCW-1:0] frag_src,
  input  logic [XW-1:0]   frag_xing,
  input  logic [RW-1:0]   frag_bits,
  output logic            ev_valid,
  output logic [XW-1:0]   ev_xing,
  output logic [CW-1:0]   ev_bits,
  output logic            ev_to,
  output logic            coll
);
  logic            sl_vld  [NSL];
  logic [XW-1:0]   sl_xing [NSL];
  logic [NSRC-1:0] sl_have [NSL];
  logic [CW-1:0]   sl_bits [NSL];
  logic [TOW-1:0]  sl_age  [NSL];

  logic            nx_vld  [NSL];
  logic [XW-1:0]   nx_xing [NSL];
  logic [NSRC-1:0] nx_have [NSL];
  logic [CW-1:0]   nx_bits [NSL];
  logic [TOW-1:0]  nx_age  [NSL];

  logic              ev_valid_n, ev_to_n, coll_n;
  logic [XW-1:0]     ev_xing_n;
  logic [CW-1:0]     ev_bits_n;
  logic [SLOT_W-1:0] idx, to_sel;
  logic              to_found, complete;
  logic [NSRC-1:0]   mrg_have;
  logic [CW-1:0]     mrg_bits;
  slot_op_e          op;

  assign idx = frag_xing[SLOT_W-1:0];

  always_comb begin
    if (!frag_valid)                     op = OP_IDLE;
    else if (!sl_vld[idx])               op = OP_INSTALL;
    else if (sl_xing[idx] == frag_xing)  op = OP_MERGE;
    else                                 op = OP_EVICT;
  end

  always_comb begin
    mrg_have = (op == OP_MERGE) ? sl_have[idx] : '0;
    mrg_bits = (op == OP_MERGE) ? sl_bits[idx] : '0;
    mrg_have = mrg_have | (NSRC'(1) << frag_src);
    mrg_bits = mrg_bits | (CW'(frag_bits) << (int'(frag_src) * RW));
    complete = (op != OP_IDLE) && (&mrg_have);
  end

  always_comb begin
    to_found = 1'b0;
    to_sel   = '0;
    for (int i = NSL - 1; i >= 0; i--) begin
      if (sl_vld[i] && (sl_age[i] == TOW'(TIMEOUT)) &&
          !(frag_valid && (idx == SLOT_W'(i)))) begin
        to_found = 1'b1;
        to_sel   = SLOT_W'(i);
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NSL; i++) begin
      nx_vld[i]  = sl_vld[i];
      nx_xing[i] = sl_xing[i];
      nx_have[i] = sl_have[i];
      nx_bits[i] = sl_bits[i];
      nx_age[i]  = (sl_vld[i] && (sl_age[i] != TOW'(TIMEOUT))) ?
                   sl_age[i] + 1'b1 : sl_age[i];
    end
    ev_valid_n = 1'b0;
    ev_to_n    = 1'b0;
    ev_xing_n  = frag_xing;
    ev_bits_n  = mrg_bits;
    coll_n     = (op == OP_EVICT);
    if (op != OP_IDLE) begin
      if (complete) begin
        nx_vld[idx] = 1'b0;
        nx_age[idx] = '0;
        ev_valid_n  = 1'b1;
      end else begin
        nx_vld[idx]  = 1'b1;
        nx_xing[idx] = frag_xing;
        nx_have[idx] = mrg_have;
        nx_bits[idx] = mrg_bits;
        if (op != OP_MERGE) nx_age[idx] = '0;
      end
    end
    if (!complete && to_found) begin
      nx_vld[to_sel] = 1'b0;
      nx_age[to_sel] = '0;
      ev_valid_n     = 1'b1;
      ev_to_n        = 1'b1;
      ev_xing_n      = sl_xing[to_sel];
      ev_bits_n      = sl_bits[to_sel];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSL; i++) begin
        sl_vld[i] <= 1'b0;
        sl_age[i] <= '0;
      end
      ev_valid <= 1'b0;
      coll     <= 1'b0;
    end else begin
      for (int i = 0; i < NSL; i++) begin
        sl_vld[i] <= nx_vld[i];
        sl_age[i] <= nx_age[i];
      end
      ev_valid <= ev_valid_n;
      coll     <= coll_n;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NSL; i++) begin
      sl_xing[i] <= nx_xing[i];
      sl_have[i] <= nx_have[i];
      sl_bits[i] <= nx_bits[i];
    end
    if (ev_valid_n) begin
      ev_xing <= ev_xing_n;
      ev_bits <= ev_bits_n;
      ev_to   <= ev_to_n;
    end
  end
endmodule

// File: rtl/trg_eval.sv
module trg_eval #(
  parameter int NTRIG = 2,
  parameter int CW    = 6,
  parameter int PSW   = 3,
  parameter int XW    = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ev_valid,
  input  logic [XW-1:0]        ev_xing,
  input  logic [CW-1:0]        ev_bits,
  input  logic                 ev_to,
  input  logic [NTRIG*CW-1:0]  cfg_mask,
  input  logic [NTRIG*PSW-1:0] cfg_prescale,
  output logic                 acc_pulse,
  output logic [NTRIG-1:0]     acc_trig,
  output logic [XW-1:0]        acc_xing,
  output logic                 acc_timeout
);
  logic [NTRIG-1:0] fire;

  for (genvar t = 0; t < NTRIG; t++) begin : g_trig
    logic [CW-1:0]  mask;
    logic [PSW-1:0] ps, cnt, cnt_n;
    logic           hit;
    assign mask = cfg_mask[t*CW +: CW];
    assign ps   = cfg_prescale[t*PSW +: PSW];

    always_comb begin
      hit     = ev_valid && ((ev_bits & mask) == mask) && (ps != '0);
      fire[t] = hit && (cnt >= ps - 1'b1);
      cnt_n   = cnt;
      if (hit) cnt_n = fire[t] ? '0 : cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_pulse   <= 1'b0;
      acc_trig    <= '0;
      acc_timeout <= 1'b0;
    end else begin
      acc_pulse   <= |fire;
      acc_trig    <= fire;
      acc_timeout <= ev_to && (|fire);
    end
  end

  always_ff @(posedge clk) begin
    if (|fire) acc_xing <= ev_xing;
  end
endmodule

// File: rtl/trg_xing_queue.sv
module trg_xing_queue #(
  parameter int XW     = 6,
  parameter int QDEPTH = 4,
  localparam int QAW   = (QDEPTH > 1) ? $clog2(QDEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [XW-1:0] push_xing,
  input  logic          pop,
  output logic          empty,
  output logic [XW-1:0] head
);
  logic [XW-1:0] mem [QDEPTH];
  logic [QAW-1:0] wr_ptr, rd_ptr, wr_ptr_n, rd_ptr_n;
  logic [QAW:0]   cnt, cnt_n;
  logic           do_push, do_pop;

  assign empty = (cnt == '0);
  assign head  = mem[rd_ptr];

  function automatic logic [QAW-1:0] step(input logic [QAW-1:0] p);
    return (p == QAW'(QDEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    do_pop   = pop && !empty;
    do_push  = push && ((cnt != (QAW+1)'(QDEPTH)) || do_pop);
    wr_ptr_n = do_push ? step(wr_ptr) : wr_ptr;
    rd_ptr_n = do_pop  ? step(rd_ptr) : rd_ptr;
    cnt_n    = cnt + (do_push ? 1'b1 : 1'b0) - (do_pop ? 1'b1 : 1'b0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      wr_ptr <= wr_ptr_n;
      rd_ptr <= rd_ptr_n;
      cnt    <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_xing;
  end
endmodule

// File: rtl/trg_collect.sv
module trg_collect #(
  parameter int NSRC    = 3,
  parameter int RW      = 2,
  parameter int XW      = 6,
  parameter int SLOT_W  = 2,
  parameter int TIMEOUT = 12,
  parameter int NTRIG   = 2,
  parameter int PSW     = 3,
  parameter int QDEPTH  = 4,
  localparam int SRCW   = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int CW     = NSRC * RW,
  localparam int TW     = (NTRIG > 1) ? $clog2(NTRIG) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frag_valid,
  input  logic [SRCW-1:0]      frag_src,
  input  logic [XW-1:0]        frag_xing,
  input  logic [RW-1:0]        frag_bits,
  input  logic [NTRIG*CW-1:0]  cfg_mask,
  input  logic [NTRIG*PSW-1:0] cfg_prescale,
  input  logic                 req_valid,
  input  logic [TW-1:0]        req_trig,
  output logic                 acc_pulse,
  output logic [NTRIG-1:0]     acc_trig,
  output logic [XW-1:0]        acc_xing,
  output logic                 acc_timeout,
  output logic                 err_collision,
  output logic                 resp_valid,
  output logic                 resp_avail,
  output logic [XW-1:0]        resp_xing
);
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  logic          ev_valid, ev_to;
  logic [XW-1:0] ev_xing;
  logic [CW-1:0] ev_bits;

  trg_frag_table #(
    .NSRC(NSRC), .RW(RW), .XW(XW), .SLOT_W(SLOT_W), .TIMEOUT(TIMEOUT)
  ) u_table (
    .clk(clk), .rst_n(rst_int_n),
    .frag_valid(frag_valid), .frag_src(frag_src),
    .frag_xing(frag_xing), .frag_bits(frag_bits),
    .ev_valid(ev_valid), .ev_xing(ev_xing), .ev_bits(ev_bits),
    .ev_to(ev_to), .coll(err_collision)
  );

  trg_eval #(.NTRIG(NTRIG), .CW(CW), .PSW(PSW), .XW(XW)) u_eval (
    .clk(clk), .rst_n(rst_int_n),
    .ev_valid(ev_valid), .ev_xing(ev_xing), .ev_bits(ev_bits), .ev_to(ev_to),
    .cfg_mask(cfg_mask), .cfg_prescale(cfg_prescale),
    .acc_pulse(acc_pulse), .acc_trig(acc_trig),
    .acc_xing(acc_xing), .acc_timeout(acc_timeout)
  );

  logic [NTRIG-1:0] q_empty, q_pop;
  logic [XW-1:0]    q_head [NTRIG];

  for (genvar t = 0; t < NTRIG; t++) begin : g_q
    assign q_pop[t] = req_valid && (req_trig == TW'(t)) && !q_empty[t];
    trg_xing_queue #(.XW(XW), .QDEPTH(QDEPTH)) u_q (
      .clk(clk), .rst_n(rst_int_n),
      .push(acc_trig[t]), .push_xing(acc_xing),
      .pop(q_pop[t]), .empty(q_empty[t]), .head(q_head[t])
    );
  end

  logic          resp_valid_n, resp_avail_n;
  logic [XW-1:0] resp_xing_n;

  always_comb begin
    resp_valid_n = req_valid;
    resp_avail_n = req_valid && !q_empty[req_trig];
    resp_xing_n  = resp_avail_n ? q_head[req_trig] : '0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      resp_valid <= 1'b0;
      resp_avail <= 1'b0;
      resp_xing  <= '0;
    end else begin
      resp_valid <= resp_valid_n;
      resp_avail <= resp_avail_n;
      resp_xing  <= resp_xing_n;
    end
  end
endmodule

// File: rtl/trg_collect_chk.sv
module trg_collect_chk #(
  parameter int NTRIG = 2,
  parameter int PSW   = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 frag_valid,
  input logic                 req_valid,
  input logic [NTRIG*PSW-1:0] cfg_prescale,
  input logic                 acc_pulse,
  input logic [NTRIG-1:0]     acc_trig,
  input logic                 acc_timeout,
  input logic                 err_collision,
  input logic                 resp_valid,
  input logic                 resp_avail
);
  AST_RESP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(req_valid)); // R7

  AST_AVAIL_IN_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    resp_avail |-> resp_valid); // R8

  AST_JOIN_NEEDS_FRAG: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_pulse && !acc_timeout) |-> $past(frag_valid, 2)); // R2

  AST_COLLIDE_NEEDS_FRAG: assert property (@(posedge clk) disable iff (!rst_n)
    err_collision |-> $past(frag_valid)); // R11

  AST_TIMEOUT_WITH_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_timeout |-> (acc_trig != '0)); // R10

  for (genvar t = 0; t < NTRIG; t++) begin : g_ps
    AST_ZERO_PRESCALE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      acc_trig[t] |-> $past(cfg_prescale[t*PSW +: PSW] != '0)); // R5
  end
endmodule

bind trg_collect trg_collect_chk #(.NTRIG(NTRIG), .PSW(PSW)) u_chk (
  .clk(clk), .rst_n(rst_n), .frag_valid(frag_valid), .req_valid(req_valid),
  .cfg_prescale(cfg_prescale), .acc_pulse(acc_pulse), .acc_trig(acc_trig),
  .acc_timeout(acc_timeout), .err_collision(err_collision),
  .resp_valid(resp_valid), .resp_avail(resp_avail)
);

// File: tb/tb_trg_collect.sv
module tb_trg_collect;
  localparam int CLK_PERIOD = 10;
  localparam int TO = 12;
  localparam logic [5:0] M0 = 6'b000011;
  localparam logic [5:0] M1 = 6'b010100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frag_valid = 1'b0;
  logic [1:0]  frag_src = '0;
  logic [5:0]  frag_xing = '0;
  logic [1:0]  frag_bits = '0;
  logic [11:0] cfg_mask = {M1, M0};
  logic [5:0]  cfg_prescale = {3'd1, 3'd1};
  logic        req_valid = 1'b0;
  logic        req_trig = 1'b0;
  logic        acc_pulse, acc_timeout, err_collision;
  logic [1:0]  acc_trig;
  logic [5:0]  acc_xing, resp_xing;
  logic        resp_valid, resp_avail;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trg_collect dut (
    .clk(clk), .rst_n(rst_n), .frag_valid(frag_valid), .frag_src(frag_src),
    .frag_xing(frag_xing), .frag_bits(frag_bits), .cfg_mask(cfg_mask),
    .cfg_prescale(cfg_prescale), .req_valid(req_valid), .req_trig(req_trig),
    .acc_pulse(acc_pulse), .acc_trig(acc_trig), .acc_xing(acc_xing),
    .acc_timeout(acc_timeout), .err_collision(err_collision),
    .resp_valid(resp_valid), .resp_avail(resp_avail), .resp_xing(resp_xing)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int order(input int p, input int k);
    int first, lo, hi;
    first = p / 2;
    lo = (first == 0) ? 1 : 0;
    hi = (first == 2) ? 1 : 2;
    if (k == 0) return first;
    if (k == 1) return (p % 2 == 0) ? lo : hi;
    return (p % 2 == 0) ? hi : lo;
  endfunction

  task automatic send(input int s, input int x, input int b);
    frag_valid = 1'b1;
    frag_src   = 2'(s);
    frag_xing  = 6'(x);
    frag_bits  = 2'(b);
    @(posedge clk); #1;
    frag_valid = 1'b0;
  endtask

  // Sends all three fragments in order p; returns one cycle after completion
  task automatic crossing(input int p, input int x, input int v);
    for (int k = 0; k < 3; k++) begin
      if (k == 2) check("R3 no accept before last fragment", acc_pulse, 0);
      send(order(p, k), x, (v >> (2 * order(p, k))) & 3);
    end
    @(posedge clk); #1;
  endtask

  task automatic request(input int t, output int avail, output int xg);
    req_valid = 1'b1;
    req_trig  = t[0];
    @(posedge clk); #1;
    req_valid = 1'b0;
    check("R7 resp_valid after request", resp_valid, 1);
    avail = resp_avail;
    xg    = resp_xing;
  endtask

  task automatic expect_q(input int t, input int avail_e, input int x_e, input string tag);
    int a, xg;
    request(t, a, xg);
    check(tag, a, avail_e);
    if (avail_e != 0) check(tag, xg, x_e);
  endtask

  initial begin
    int p0, p1, a, xg, n;
    #(3*CLK_PERIOD + 2);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R1 / R8: clean state after reset
    check("R1 acc_pulse idle", acc_pulse, 0);
    check("R1 err_collision idle", err_collision, 0);
    check("R1 resp_valid idle", resp_valid, 0);
    expect_q(0, 0, 0, "R1 R8 queue0 empty after reset");
    expect_q(1, 0, 0, "R1 R8 queue1 empty after reset");

    // R2 R4 R6 R7: every arrival order against every result pattern
    for (int p = 0; p < 6; p++) begin
      for (int v = 0; v < 64; v++) begin
        p0 = ((v & M0) == M0) ? 1 : 0;
        p1 = ((v & M1) == M1) ? 1 : 0;
        crossing(p, v, v);
        check("R2 R4 acc_pulse", acc_pulse, p0 | p1);
        check("R4 R6 acc_trig", acc_trig, p0 + 2 * p1);
        check("R6 acc_timeout clear", acc_timeout, 0);
        if (p0 | p1) check("R6 acc_xing", acc_xing, v);
        @(posedge clk); #1;
        expect_q(0, p0, v, "R7 queue0 entry");
        expect_q(1, p1, v, "R7 queue1 entry");
      end
    end

    // R9 R7: overfill both queues, order kept, overflow dropped
    for (int k = 0; k < 6; k++) crossing(k % 6, 20 + k, 63);
    @(posedge clk); #1;
    for (int k = 0; k < 4; k++) expect_q(0, 1, 20 + k, "R9 R7 queue0 order when full");
    expect_q(0, 0, 0, "R9 queue0 overflow dropped");
    for (int k = 0; k < 4; k++) expect_q(1, 1, 20 + k, "R9 R7 queue1 order when full");
    expect_q(1, 0, 0, "R9 queue1 overflow dropped");
    expect_q(1, 0, 0, "R8 repeated empty request");

    // R5: prescale 3 on trigger0, trigger1 disabled
    cfg_prescale = {3'd0, 3'd3};
    for (int k = 0; k < 7; k++) begin
      crossing(k % 6, 30 + k, 63);
      check("R5 prescale 3 acc_trig0", acc_trig[0], (k % 3 == 2) ? 1 : 0);
      check("R5 prescale 0 acc_trig1", acc_trig[1], 0);
      check("R5 acc_pulse with prescale", acc_pulse, (k % 3 == 2) ? 1 : 0);
    end
    @(posedge clk); #1;
    expect_q(0, 1, 32, "R5 queue0 first prescaled");
    expect_q(0, 1, 35, "R5 queue0 second prescaled");
    expect_q(0, 0, 0, "R5 queue0 empty");
    expect_q(1, 0, 0, "R5 disabled trigger queue empty");
    cfg_prescale = {3'd1, 3'd1};

    // R10: source 2 never reports
    send(0, 50, 3);
    n = 0;
    send(1, 50, 1);
    n = 1;
    while (n < 40) begin
      @(posedge clk); #1;
      n++;
      if (acc_pulse) break;
    end
    check("R10 timeout latency", n, TO + 2);
    check("R10 acc_timeout set", acc_timeout, 1);
    check("R10 missing bits cleared acc_trig", acc_trig, 1);
    check("R10 acc_xing", acc_xing, 50);
    @(posedge clk); #1;
    expect_q(0, 1, 50, "R10 timed-out crossing queued");
    expect_q(1, 0, 0, "R10 trigger1 not queued");

    // R11: crossing 13 aliases crossing 9 in slot 1
    send(0, 9, 3);
    check("R11 no collision on install", err_collision, 0);
    send(0, 13, 3);
    check("R11 collision raised", err_collision, 1);
    send(1, 13, 3);
    check("R11 collision one cycle", err_collision, 0);
    send(2, 13, 3);
    @(posedge clk); #1;
    check("R11 new crossing accepted", acc_pulse, 1);
    check("R11 new crossing number", acc_xing, 13);
    n = 0;
    for (int k = 0; k < TO + 6; k++) begin
      @(posedge clk); #1;
      if (acc_pulse) n++;
    end
    check("R11 evicted crossing never accepted", n, 0);
    expect_q(0, 1, 13, "R11 queue0 holds new only");
    expect_q(0, 0, 0, "R11 queue0 nothing else");
    expect_q(1, 1, 13, "R11 queue1 holds new only");
    expect_q(1, 0, 0, "R11 queue1 nothing else");

    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    end
    #1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule